// File: doc/BRIEF.md
# Watchdog Timer with Pulse or Level Reset Output

This block is a watchdog counter that sits inside a byte-wide configuration bank. Software loads an 8-bit timeout count. While the watchdog is running, the count falls by one for each elapsed time unit, and the unit is either one second or one minute. Every write of the count register reloads it, and that write is the keepalive. If software stops writing the count, it runs out. The block then raises a sticky timeout status bit and pulls the active-low reset pin. Depending on configuration, the pin either stays low as a held level or gives one pulse of a chosen width.

All timing comes from a one-cycle millisecond tick input. A parameter sets how many ticks make one second, and a minute is sixty seconds. The host reaches the bank through single-cycle write and read strobes that carry a register index and a data byte. There is no back-pressure: a strobe always completes in the cycle it is presented. The read data is combinational and is valid only while the read strobe is high. The status bit is cleared only by the power-on reset or by writing one to it. It therefore survives the system reset that the pin causes, and software can find out after restart why the system was reset.

Top module: `wdog_bank`

## Requirements
- R1: After power-on reset the output-enable register (index 0xF0), the control register (index 0xF5) and the count register (index 0xF6) all read 0x00, and `wdt_rst_n` is 1.
- R2: A write to index 0xF6 loads the count with the written byte. It also restarts the unit prescaler, so the full timeout begins again from that write.
- R3: Control bit 3 selects the unit: 0 means one unit is MS_PER_SEC ticks, 1 means one unit is 60*MS_PER_SEC ticks. With `ms_tick` high every cycle, a load of N≥1 expires N units after the load edge, and a load of 0 expires after one unit.
- R4: The count and the prescaler change only while both `ld_enable` and control bit 5 are 1. Otherwise the count holds. When counting becomes enabled, a held count restarts its countdown.
- R5: Control bit 6 is set by an expiry and cleared by writing the control register with bit 6 equal to 1. When both happen in the same cycle, the set wins. Only `por_n` clears it otherwise.
- R6: With control bit 4 = 1, an expiry drives `wdt_rst_n` low for exactly 1, 25, 125 or 5000 ticks for width codes 0, 1, 2 and 3 in control bits 1:0.
- R7: With control bit 4 = 0, `wdt_rst_n` is low from the cycle after expiry until the status bit or control bit 5 is cleared.
- R8: Output-enable register bit 7 gates the pin. While it is 0, `wdt_rst_n` stays 1 even with status set.
- R9: While `rd_en` is 1, `rd_data` returns the indexed register, and unused bits and unmapped indices read 0. Index 0xF6 returns the remaining count. While `rd_en` is 0, `rd_data` is 0.
- R10: A load expires at most once. After an expiry, no further expiry occurs until the count is rewritten or counting is re-enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Active-low power-on reset, clears every register |
| ld_enable | input | 1 | Logical-device enable; must be 1 for counting |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_idx | input | 8 | Register index |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid while `rd_en` is high |
| wdt_rst_n | output | 1 | Active-low reset output |

## Verification
Two events can land on the same clock edge: an expiry, which sets the status bit, and a control write that clears that bit. The bench loads a count of one and then waits idle for exactly enough cycles that the write-one-to-clear reaches the edge on which the unit tick expires the count. The test passes if the status bit reads 1 afterwards and the level-mode pin is low. A second collision is also provoked: a keepalive rewrite issued partway through a countdown. It is judged by checking that the pin stays high and that expiry is measured from the rewrite.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [7:0] IDX_OUT = 8'hF0;
  localparam logic [7:0] IDX_CTL = 8'hF5;
  localparam logic [7:0] IDX_CNT = 8'hF6;

  localparam int BIT_OUT_EN = 7;
  localparam int BIT_STS    = 6;
  localparam int BIT_EN     = 5;
  localparam int BIT_PULSE  = 4;
  localparam int BIT_UNIT   = 3;

  localparam int PW_BITS = 13;

  typedef struct packed {
    logic       en;
    logic       pulse;
    logic       unit_min;
    logic [1:0] width;
  } wd_cfg_t;

  function automatic logic [PW_BITS-1:0] pulse_len(input logic [1:0] code);
    case (code)
      2'd0:    return PW_BITS'(1);
      2'd1:    return PW_BITS'(25);
      2'd2:    return PW_BITS'(125);
      default: return PW_BITS'(5000);
    endcase
  endfunction
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [7:0]    reg_idx,
  input  logic [7:0]    wr_data,
  input  logic          expire_evt,
  input  logic [CW-1:0] count,
  output wd_cfg_t       cfg,
  output logic          status,
  output logic          out_en,
  output logic          cnt_load,
  output logic [7:0]    rd_data
);
  logic wr_ctl, wr_out;

  assign wr_ctl   = wr_en && (reg_idx == IDX_CTL);
  assign wr_out   = wr_en && (reg_idx == IDX_OUT);
  assign cnt_load = wr_en && (reg_idx == IDX_CNT);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cfg    <= '0;
      status <= 1'b0;
      out_en <= 1'b0;
    end else begin
      if (wr_ctl) begin
        cfg.en       <= wr_data[BIT_EN];
        cfg.pulse    <= wr_data[BIT_PULSE];
        cfg.unit_min <= wr_data[BIT_UNIT];
        cfg.width    <= wr_data[1:0];
      end
      if (wr_out) out_en <= wr_data[BIT_OUT_EN];
      // expiry has priority over the write-one-to-clear
      if (expire_evt)                      status <= 1'b1;
      else if (wr_ctl && wr_data[BIT_STS]) status <= 1'b0;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      case (reg_idx)
        IDX_OUT: rd_data[BIT_OUT_EN] = out_en;
        IDX_CTL: begin
          rd_data[BIT_STS]   = status;
          rd_data[BIT_EN]    = cfg.en;
          rd_data[BIT_PULSE] = cfg.pulse;
          rd_data[BIT_UNIT]  = cfg.unit_min;
          rd_data[1:0]       = cfg.width;
        end
        IDX_CNT: rd_data = 8'(count);
        default: rd_data = '0;
      endcase
    end
  end

  p_status_set_r5: assert property (@(posedge clk) disable iff (!por_n)
    expire_evt |=> status);
  p_w1c_r5: assert property (@(posedge clk) disable iff (!por_n)
    (wr_ctl && wr_data[BIT_STS] && !expire_evt) |=> !status);
endmodule

// File: rtl/wdog_timebase.sv
module wdog_timebase #(
  parameter int MS_PER_SEC = 1000
) (
  input  logic clk,
  input  logic por_n,
  input  logic ms_tick,
  input  logic running,
  input  logic restart,
  input  logic unit_min,
  output logic unit_tick
);
  localparam int MSW = (MS_PER_SEC > 1) ? $clog2(MS_PER_SEC) : 1;
  localparam int SEC_PER_MIN = 60;

  logic [MSW-1:0] ms_cnt;
  logic [5:0]     sec_cnt;
  logic           ms_wrap, sec_wrap;

  assign ms_wrap   = ms_tick && (ms_cnt == MSW'(MS_PER_SEC - 1));
  assign sec_wrap  = (sec_cnt == 6'(SEC_PER_MIN - 1));
  assign unit_tick = running && !restart && ms_wrap && (!unit_min || sec_wrap);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ms_cnt  <= '0;
      sec_cnt <= '0;
    end else if (!running || restart) begin
      ms_cnt  <= '0;
      sec_cnt <= '0;
    end else if (ms_tick) begin
      if (ms_wrap) begin
        ms_cnt  <= '0;
        sec_cnt <= sec_wrap ? 6'd0 : sec_cnt + 6'd1;
      end else begin
        ms_cnt <= ms_cnt + MSW'(1);
      end
    end
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          running,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          unit_tick,
  output logic [CW-1:0] count,
  output logic          expire_evt
);
  logic run_d, armed, at_end;

  assign at_end     = (count == '0) || (count == CW'(1));
  assign expire_evt = unit_tick && armed && !load && at_end;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      count <= '0;
      armed <= 1'b0;
      run_d <= 1'b0;
    end else begin
      run_d <= running;
      if (load) begin
        count <= load_val;
        armed <= 1'b1;
      end else begin
        if (running && !run_d) armed <= 1'b1;
        if (unit_tick && armed) begin
          if (at_end) begin
            count <= '0;
            armed <= 1'b0;
          end else begin
            count <= count - CW'(1);
          end
        end
      end
    end
  end

  p_expire_needs_run_r4: assert property (@(posedge clk) disable iff (!por_n)
    expire_evt |-> running);
  p_count_hold_r4: assert property (@(posedge clk) disable iff (!por_n)
    (!running && !load) |=> $stable(count));
endmodule

// File: rtl/wdog_pin.sv
module wdog_pin
  import wdog_pkg::*;
(
  input  logic    clk,
  input  logic    por_n,
  input  logic    ms_tick,
  input  logic    expire_evt,
  input  wd_cfg_t cfg,
  input  logic    status,
  input  logic    out_en,
  output logic    wdt_rst_n
);
  logic [PW_BITS-1:0] pulse_cnt;
  logic               pulse_act, level_act;

  assign pulse_act = (pulse_cnt != '0);
  assign level_act = status && cfg.en && !cfg.pulse;
  assign wdt_rst_n = !(out_en && (level_act || pulse_act));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                      pulse_cnt <= '0;
    else if (expire_evt && cfg.pulse) pulse_cnt <= pulse_len(cfg.width);
    else if (ms_tick && pulse_act)    pulse_cnt <= pulse_cnt - PW_BITS'(1);
  end

  p_pulse_start_r6: assert property (@(posedge clk) disable iff (!por_n)
    (expire_evt && cfg.pulse) |=> pulse_act);
  p_pin_gated_r8: assert property (@(posedge clk) disable iff (!por_n)
    $fell(out_en) |-> ##0 wdt_rst_n);
endmodule

// File: rtl/wdog_bank.sv
module wdog_bank
  import wdog_pkg::*;
#(
  parameter int MS_PER_SEC = 1000,
  parameter int CW         = 8
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       ld_enable,
  input  logic       ms_tick,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] reg_idx,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       wdt_rst_n
);
  wd_cfg_t       cfg;
  logic          status, out_en, cnt_load, running, unit_tick, expire_evt;
  logic [CW-1:0] count;

  assign running = ld_enable && cfg.en;

  wdog_regs #(.CW(CW)) u_regs (
    .clk(clk), .por_n(por_n), .wr_en(wr_en), .rd_en(rd_en), .reg_idx(reg_idx),
    .wr_data(wr_data), .expire_evt(expire_evt), .count(count), .cfg(cfg),
    .status(status), .out_en(out_en), .cnt_load(cnt_load), .rd_data(rd_data)
  );

  wdog_timebase #(.MS_PER_SEC(MS_PER_SEC)) u_tb (
    .clk(clk), .por_n(por_n), .ms_tick(ms_tick), .running(running),
    .restart(cnt_load), .unit_min(cfg.unit_min), .unit_tick(unit_tick)
  );

  wdog_counter #(.CW(CW)) u_cnt (
    .clk(clk), .por_n(por_n), .running(running), .load(cnt_load),
    .load_val(CW'(wr_data)), .unit_tick(unit_tick), .count(count),
    .expire_evt(expire_evt)
  );

  wdog_pin u_pin (
    .clk(clk), .por_n(por_n), .ms_tick(ms_tick), .expire_evt(expire_evt),
    .cfg(cfg), .status(status), .out_en(out_en), .wdt_rst_n(wdt_rst_n)
  );
endmodule

// File: tb/test_wdog_bank.sv
module test_wdog_bank;
  localparam int MSPS = 3;
  localparam int USEC = MSPS;
  localparam int UMIN = 60 * MSPS;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       ld_enable = 1'b1;
  logic       ms_tick = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] reg_idx = '0, wr_data = '0;
  logic [7:0] rd_data;
  logic       wdt_rst_n;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  wdog_bank #(.MS_PER_SEC(MSPS), .CW(8)) i_wdog_bank (
    .clk(clk), .por_n(por_n), .ld_enable(ld_enable), .ms_tick(ms_tick),
    .wr_en(wr_en), .rd_en(rd_en), .reg_idx(reg_idx), .wr_data(wr_data),
    .rd_data(rd_data), .wdt_rst_n(wdt_rst_n)
  );

  // {count[7:0], unit_min, pulse, width[1:0], latency[15:0], low[15:0]}; low 0 = held level
  localparam int NV = 6;
  localparam logic [43:0] VEC [NV] = '{
    {8'd3, 1'b0, 1'b0, 2'd0, 16'd9,   16'd0},
    {8'd1, 1'b0, 1'b1, 2'd0, 16'd3,   16'd1},
    {8'd2, 1'b0, 1'b1, 2'd1, 16'd6,   16'd25},
    {8'd0, 1'b0, 1'b1, 2'd2, 16'd3,   16'd125},
    {8'd2, 1'b1, 1'b1, 2'd3, 16'd360, 16'd5000},
    {8'd4, 1'b0, 1'b0, 2'd0, 16'd12,  16'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] idx, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; reg_idx = idx; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] idx, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; reg_idx = idx;
    #1 d = rd_data;
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // edges after the load until pin falls (capped)
  task automatic wait_low(input int cap, output int n);
    n = 0;
    while (wdt_rst_n && n < cap) begin
      @(posedge clk); #1; n++;
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    idle(200000 - 100);
    errors++; checks++;
    $display("FAIL watchdog timeout of bench");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    int lat, low;
    idle(3);
    #1 por_n = 1'b1;
    // R1 reset state
    chk("R1 pin", wdt_rst_n, 1'b1);
    rd(8'hF0, d); chk("R1 out", d, 8'h00);
    rd(8'hF5, d); chk("R1 ctl", d, 8'h00);
    rd(8'hF6, d); chk("R1 cnt", d, 8'h00);
    // R9 unmapped index and idle read bus
    rd(8'h10, d); chk("R9 unmapped", d, 8'h00);
    wr(8'hF0, 8'hFF);
    rd(8'hF0, d); chk("R9 unused bits", d, 8'h80);
    @(negedge clk); chk("R9 rd_en low", rd_data, 8'h00);

    // vector table: R3 R6 R7
    for (int i = 0; i < NV; i++) begin
      logic [7:0] n; logic um, pm; logic [1:0] w; int el, ew;
      {n, um, pm, w} = VEC[i][43:32];
      el = int'(VEC[i][31:16]); ew = int'(VEC[i][15:0]);
      wr(8'hF5, {1'b0, 1'b1, 1'b1, pm, um, 1'b0, w});
      wr(8'hF6, n);
      wait_low(el + 20, lat);
      chk($sformatf("R3 latency vec%0d", i), lat, el);
      if (ew != 0) begin
        low = 1;
        while (low < 6000) begin
          @(posedge clk); #1;
          if (wdt_rst_n) break;
          low++;
        end
        chk($sformatf("R6 pulse width vec%0d", i), low, ew);
      end else begin
        low = 0;
        for (int k = 0; k < 40; k++) begin
          @(posedge clk); #1;
          if (!wdt_rst_n) low++;
        end
        chk($sformatf("R7 level held vec%0d", i), low, 40);
        wr(8'hF5, 8'h60);
        chk($sformatf("R7 released by clear vec%0d", i), wdt_rst_n, 1'b1);
        rd(8'hF5, d); chk($sformatf("R5 w1c vec%0d", i), d, 8'h20);
      end
      if (i == 1) begin
        // R10 no re-fire after a pulse
        low = 0;
        for (int k = 0; k < 20; k++) begin
          @(posedge clk); #1;
          if (!wdt_rst_n) low++;
        end
        chk("R10 no second expiry", low, 0);
      end
    end

    // R2 keepalive restarts the timeout, R9 count read-back
    wr(8'hF5, 8'h60);
    wr(8'hF6, 8'd5);
    idle(3);
    rd(8'hF6, d); chk("R9 remaining count", d, 8'd4);
    wr(8'hF6, 8'd3);
    idle(7);
    chk("R2 high before keepalive", wdt_rst_n, 1'b1);
    wr(8'hF6, 8'd3);
    wait_low(40, lat);
    chk("R2 latency after keepalive", lat, 3 * USEC);
    wr(8'hF5, 8'h60);

    // R4 logical-device gate holds the count
    ld_enable = 1'b0;
    wr(8'hF6, 8'd2);
    idle(30);
    chk("R4 gated pin", wdt_rst_n, 1'b1);
    rd(8'hF6, d); chk("R4 count held", d, 8'd2);
    @(negedge clk); ld_enable = 1'b1;
    wait_low(40, lat);
    chk("R4 counts once enabled", wdt_rst_n, 1'b0);
    wr(8'hF5, 8'h60);

    // R5 collision: W1C and expiry on the same edge, set wins
    wr(8'hF6, 8'd1);
    idle(2);
    wr(8'hF5, 8'h60);
    rd(8'hF5, d); chk("R5 set wins", d, 8'h60);
    chk("R5 collision pin", wdt_rst_n, 1'b0);

    // R7 disable releases pin, R5 status survives
    wr(8'hF5, 8'h00);
    chk("R7 disable releases", wdt_rst_n, 1'b1);
    rd(8'hF5, d); chk("R5 status kept", d, 8'h40);

    // R8 pin gate
    wr(8'hF0, 8'h00);
    wr(8'hF5, 8'h20);
    low = 0;
    for (int k = 0; k < 10; k++) begin
      @(posedge clk); #1;
      if (!wdt_rst_n) low++;
    end
    chk("R8 pin gated off", low, 0);
    wr(8'hF0, 8'h80);
    chk("R8 pin gated on", wdt_rst_n, 1'b0);
    wr(8'hF5, 8'h40);
    rd(8'hF5, d); chk("R5 cleared", d, 8'h00);
    chk("R7 idle pin", wdt_rst_n, 1'b1);
    finish_run();
  end
endmodule